// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a clock synthesizer's internal clocks and its output pins. It passes a group of processor clocks and a group of peripheral-bus clocks, each derived from its own source clock. Each group can be halted by an active-low request that arrives asynchronously. Each output can also be disabled on its own by a bit in an enable mask. One extra peripheral-bus output runs freely. Neither stop request affects it, and only its own enable bit can halt it.

Each stop request first passes through a two-flop synchronizer in the clock domain of its group. A small state machine then decides whether the group runs. The machine guarantees a minimum number of full pulses after every restart. A stop request that arrives inside that window is held pending and is acted on as soon as the window closes. Every output goes through a latch-based gate that is transparent only while the source clock is low. Because of this, an output is always parked low and never produces a shortened pulse when stopping, restarting or changing its mask. A global tristate bit removes the output drive enable without disturbing the clocks.

Top module: `clkstop_ctrl`

## Requirements
- R1: If a group's stop input is sampled low at source-clock rising edge k, and the group's minimum-run window has expired, the last output pulse of that group starts at edge k+2. No pulse starts at edge k+3 or later while the request stays low.
- R2: If a stopped group's stop input is sampled high at rising edge j, the first output pulse starts at edge j+3. A single sampled-high cycle is enough to restart the group.
- R3: Every output high phase lasts exactly one full high phase of its source clock. A stopped or disabled output is held low.
- R4: After a restart, a group produces at least MIN_RUN pulses on each enabled output (CPU_MIN_RUN or PCI_MIN_RUN). Suppose the stop request is sampled low at edge j+d, counting from the restart edge j, and stays low. Then exactly max(MIN_RUN, d) pulses appear before the group parks.
- R5: Bit i of a group's mask controls output i of that group. A 0 holds the output low; a 1 lets it pulse while the group runs. A mask change made while the source clock is low takes effect from the next rising edge.
- R6: The two groups are independent. Stopping one group does not interrupt pulses of the other.
- R7: The free-running output pulses on every peripheral-clock cycle while its enable bit is 1, whatever either stop input does. It stays low while that bit is 0.
- R8: The drive enable output equals the inverse of the tristate input. Setting tristate does not stop any clock output.
- R9: After reset both groups run, and no minimum-run window is open. A stop request is therefore honoured with the R1 latency straight away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Source clock of the processor group |
| pci_clk | input | 1 | Source clock of the peripheral-bus group and the free output |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| cpu_stop_n | input | 1 | Asynchronous active-low stop request for the processor group |
| pci_stop_n | input | 1 | Asynchronous active-low stop request for the peripheral-bus group |
| cpu_mask | input | CPU_N | Per-output enable for the processor group, bit i for output i |
| pci_mask | input | PCI_N | Per-output enable for the peripheral-bus group, bit i for output i |
| free_en | input | 1 | Enable of the free-running peripheral-bus output |
| tristate | input | 1 | Global request to release all output drivers |
| cpu_gclk | output | CPU_N | Gated processor clocks |
| pci_gclk | output | PCI_N | Gated peripheral-bus clocks |
| pci_free_gclk | output | 1 | Free-running peripheral-bus clock |
| drive_en | output | 1 | Output drive enable, low while tristate is set |

## Verification
The bound checker runs on every cycle. It checks that the run state of each group falls only after a stop request sampled low three edges earlier, and rises only after one sampled high. A fall must never come before the minimum pulse count has been reached. An output may pulse only in a cycle whose gate enable was taken from a running group, a masked-off output stays quiet, and the free output follows its enable bit. Other properties can only be shown by the bench's scenarios: that every high phase has full width, the exact pulse counts that give the on and off latencies, the pending stop across a sweep of request offsets, the mask sweeps, independence between the two clock domains, and the tristate behaviour.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic {
        GRP_STOPPED = 1'b0,
        GRP_RUNNING = 1'b1
    } grp_state_e;

    localparam int unsigned SYNC_DEPTH_DEFAULT = 2;
endpackage

// File: rtl/clkstop_sync.sv
// Multi-flop synchronizer for an asynchronous active-low request.
// It resets to the idle (high) level.
module clkstop_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
// Latch-based clock gate. The enable is captured while the clock is low,
// so the output can only carry whole high phases.
module clkstop_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_l;

    always_latch begin
        if (!clk_i) en_l = en_i;
    end

    assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/clkstop_group.sv
// One gated clock group: request synchronizer, run/hold state machine,
// and one gate per output.
module clkstop_group
    import clkstop_pkg::*;
#(
    parameter int unsigned N           = 4,
    parameter int unsigned MIN_RUN     = 100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_n,
    input  logic [N-1:0] mask,
    output logic [N-1:0] gclk,
    output logic         run_o
);
    localparam int unsigned CW = $clog2(MIN_RUN + 1);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(MIN_RUN - 1);

    typedef struct packed {
        grp_state_e    st;
        logic [CW-1:0] hold;
    } grp_reg_t;

    grp_reg_t cur_q, nxt_d;
    logic     go_s;

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stop_n),
        .sync_o  (go_s)
    );

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            GRP_RUNNING: begin
                if (cur_q.hold != '0) nxt_d.hold = cur_q.hold - 1'b1;
                else if (!go_s)       nxt_d.st   = GRP_STOPPED;
            end
            GRP_STOPPED: begin
                if (go_s) begin
                    nxt_d.st   = GRP_RUNNING;
                    nxt_d.hold = HOLD_LOAD;
                end
            end
            default: nxt_d.st = GRP_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= GRP_RUNNING;
            cur_q.hold <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign run_o = (cur_q.st == GRP_RUNNING);

    for (genvar g = 0; g < N; g++) begin : g_gate
        clkstop_gate u_gate (
            .clk_i  (clk),
            .en_i   (run_o & mask[g]),
            .gclk_o (gclk[g])
        );
    end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int unsigned CPU_N       = 4,
    parameter int unsigned PCI_N       = 6,
    parameter int unsigned CPU_MIN_RUN = 100,
    parameter int unsigned PCI_MIN_RUN = 10,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEFAULT
) (
    input  logic             cpu_clk,
    input  logic             pci_clk,
    input  logic             rst_n,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic [CPU_N-1:0] cpu_mask,
    input  logic [PCI_N-1:0] pci_mask,
    input  logic             free_en,
    input  logic             tristate,
    output logic [CPU_N-1:0] cpu_gclk,
    output logic [PCI_N-1:0] pci_gclk,
    output logic             pci_free_gclk,
    output logic             drive_en
);
    logic cpu_run;
    logic pci_run;

    clkstop_group #(
        .N(CPU_N), .MIN_RUN(CPU_MIN_RUN), .SYNC_STAGES(SYNC_STAGES)
    ) u_cpu (
        .clk    (cpu_clk),
        .rst_n  (rst_n),
        .stop_n (cpu_stop_n),
        .mask   (cpu_mask),
        .gclk   (cpu_gclk),
        .run_o  (cpu_run)
    );

    clkstop_group #(
        .N(PCI_N), .MIN_RUN(PCI_MIN_RUN), .SYNC_STAGES(SYNC_STAGES)
    ) u_pci (
        .clk    (pci_clk),
        .rst_n  (rst_n),
        .stop_n (pci_stop_n),
        .mask   (pci_mask),
        .gclk   (pci_gclk),
        .run_o  (pci_run)
    );

    // Free-running output: gated only by its own enable bit.
    clkstop_gate u_free (
        .clk_i  (pci_clk),
        .en_i   (free_en),
        .gclk_o (pci_free_gclk)
    );

    assign drive_en = ~tristate;
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
    parameter int unsigned CPU_N       = 4,
    parameter int unsigned PCI_N       = 6,
    parameter int unsigned CPU_MIN_RUN = 100,
    parameter int unsigned PCI_MIN_RUN = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic             cpu_clk,
    input logic             pci_clk,
    input logic             rst_n,
    input logic             cpu_stop_n,
    input logic             pci_stop_n,
    input logic [CPU_N-1:0] cpu_mask,
    input logic [PCI_N-1:0] pci_mask,
    input logic             free_en,
    input logic [CPU_N-1:0] cpu_gclk,
    input logic [PCI_N-1:0] pci_gclk,
    input logic             pci_free_gclk,
    input logic             cpu_run,
    input logic             pci_run
);
    localparam int unsigned CLW = $clog2(CPU_MIN_RUN + 1);
    localparam int unsigned PLW = $clog2(PCI_MIN_RUN + 1);
    localparam logic [CLW-1:0] CPU_SAT = CLW'(CPU_MIN_RUN);
    localparam logic [PLW-1:0] PCI_SAT = PLW'(PCI_MIN_RUN);

    // Run length since the last restart, saturating at the minimum.
    logic [CLW-1:0] cpu_len;
    logic [PLW-1:0] pci_len;

    always_ff @(posedge cpu_clk or negedge rst_n) begin
        if (!rst_n)              cpu_len <= CPU_SAT;
        else if (!cpu_run)       cpu_len <= '0;
        else if (cpu_len != CPU_SAT) cpu_len <= cpu_len + 1'b1;
    end

    always_ff @(posedge pci_clk or negedge rst_n) begin
        if (!rst_n)              pci_len <= PCI_SAT;
        else if (!pci_run)       pci_len <= '0;
        else if (pci_len != PCI_SAT) pci_len <= pci_len + 1'b1;
    end

    assert_cpu_stop_cause_R1: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $fell(cpu_run) |-> !$past(cpu_stop_n, SYNC_STAGES + 1))
        else $error("cpu group stopped without a request");
    assert_pci_stop_cause_R1: assert property (@(posedge pci_clk) disable iff (!rst_n)
        $fell(pci_run) |-> !$past(pci_stop_n, SYNC_STAGES + 1))
        else $error("pci group stopped without a request");

    assert_cpu_start_cause_R2: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $rose(cpu_run) |-> $past(cpu_stop_n, SYNC_STAGES + 1))
        else $error("cpu group restarted without release");
    assert_pci_start_cause_R2: assert property (@(posedge pci_clk) disable iff (!rst_n)
        $rose(pci_run) |-> $past(pci_stop_n, SYNC_STAGES + 1))
        else $error("pci group restarted without release");

    assert_cpu_min_run_R4: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $fell(cpu_run) |-> (cpu_len == CPU_SAT))
        else $error("cpu group stopped inside its minimum run");
    assert_pci_min_run_R4: assert property (@(posedge pci_clk) disable iff (!rst_n)
        $fell(pci_run) |-> (pci_len == PCI_SAT))
        else $error("pci group stopped inside its minimum run");

    // Sampled at the falling edge, an output shows the high phase just ended.
    assert_cpu_park_R3: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        (|cpu_gclk) |-> $past(cpu_run))
        else $error("cpu output pulsed while stopped");
    assert_pci_park_R3: assert property (@(negedge pci_clk) disable iff (!rst_n)
        (|pci_gclk) |-> $past(pci_run))
        else $error("pci output pulsed while stopped");

    assert_cpu_mask_R5: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        $stable(cpu_mask) |-> ((cpu_gclk & ~cpu_mask) == '0))
        else $error("masked cpu output pulsed");
    assert_pci_mask_R5: assert property (@(negedge pci_clk) disable iff (!rst_n)
        $stable(pci_mask) |-> ((pci_gclk & ~pci_mask) == '0))
        else $error("masked pci output pulsed");

    assert_free_follow_R7: assert property (@(negedge pci_clk) disable iff (!rst_n)
        $stable(free_en) |-> (pci_free_gclk == free_en))
        else $error("free output disagrees with its enable");
endmodule

bind clkstop_ctrl clkstop_chk #(
    .CPU_N(CPU_N), .PCI_N(PCI_N), .CPU_MIN_RUN(CPU_MIN_RUN),
    .PCI_MIN_RUN(PCI_MIN_RUN), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .cpu_clk       (cpu_clk),
    .pci_clk       (pci_clk),
    .rst_n         (rst_n),
    .cpu_stop_n    (cpu_stop_n),
    .pci_stop_n    (pci_stop_n),
    .cpu_mask      (cpu_mask),
    .pci_mask      (pci_mask),
    .free_en       (free_en),
    .cpu_gclk      (cpu_gclk),
    .pci_gclk      (pci_gclk),
    .pci_free_gclk (pci_free_gclk),
    .cpu_run       (cpu_run),
    .pci_run       (pci_run)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;
    localparam int CLK_PERIOD = 10;          // processor group source clock
    localparam int PCI_PERIOD = 24;          // peripheral group source clock
    localparam int CPU_HALF   = CLK_PERIOD / 2;
    localparam int PCI_HALF   = PCI_PERIOD / 2;
    localparam int CN = 2;
    localparam int PN = 3;
    localparam int CMIN = 12;
    localparam int PMIN = 4;

    logic cpu_clk = 1'b0, pci_clk = 1'b0, rst_n = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
    logic [CN-1:0] cpu_mask = '1;
    logic [PN-1:0] pci_mask = '1;
    logic free_en = 1'b1, tristate = 1'b0;
    logic [CN-1:0] cpu_gclk;
    logic [PN-1:0] pci_gclk;
    logic pci_free_gclk, drive_en;

    int checks = 0, failures = 0, runts = 0;
    int cpu_cnt [CN];
    int pci_cnt [PN];
    int free_cnt = 0;
    bit done = 1'b0;

    always #(CPU_HALF) cpu_clk = ~cpu_clk;
    always #(PCI_HALF) pci_clk = ~pci_clk;

    clkstop_ctrl #(
        .CPU_N(CN), .PCI_N(PN), .CPU_MIN_RUN(CMIN), .PCI_MIN_RUN(PMIN), .SYNC_STAGES(2)
    ) u0 (
        .cpu_clk(cpu_clk), .pci_clk(pci_clk), .rst_n(rst_n),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .cpu_mask(cpu_mask), .pci_mask(pci_mask), .free_en(free_en),
        .tristate(tristate), .cpu_gclk(cpu_gclk), .pci_gclk(pci_gclk),
        .pci_free_gclk(pci_free_gclk), .drive_en(drive_en)
    );

    // Pulse counters: one sample 1 ns after each source rising edge.
    initial begin
        for (int i = 0; i < CN; i++) cpu_cnt[i] = 0;
        for (int i = 0; i < PN; i++) pci_cnt[i] = 0;
    end
    always @(posedge cpu_clk) begin
        #1;
        for (int i = 0; i < CN; i++) if (cpu_gclk[i]) cpu_cnt[i] = cpu_cnt[i] + 1;
    end
    always @(posedge pci_clk) begin
        #1;
        for (int i = 0; i < PN; i++) if (pci_gclk[i]) pci_cnt[i] = pci_cnt[i] + 1;
        if (pci_free_gclk) free_cnt = free_cnt + 1;
    end

    // Pulse width monitor for R3: every high phase must be a full half period.
    logic [CN+PN:0] out_vec, prev_vec = '0;
    time rise_t [CN+PN+1];
    assign out_vec = {pci_free_gclk, pci_gclk, cpu_gclk};
    always @(out_vec) begin
        for (int i = 0; i <= CN + PN; i++) begin
            if (out_vec[i] && !prev_vec[i]) rise_t[i] = $time;
            else if (!out_vec[i] && prev_vec[i])
                if (($time - rise_t[i]) != ((i < CN) ? CPU_HALF : PCI_HALF)) runts++;
        end
        prev_vec = out_vec;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_g(input bit pci, input int n);
        for (int i = 0; i < n; i++) begin
            if (pci) @(negedge pci_clk); else @(negedge cpu_clk);
        end
    endtask

    function automatic int cnt_of(input bit pci, input int idx);
        return pci ? pci_cnt[idx] : cpu_cnt[idx];
    endfunction

    task automatic set_stop(input bit pci, input logic v);
        if (pci) pci_stop_n = v; else cpu_stop_n = v;
    endtask

    // R1/R2/R3/R6 on one group; called at a negedge with the window closed.
    task automatic latency_test(input bit pci);
        int c0, o0, d, od;
        string tag;
        tag = pci ? "pci" : "cpu";
        c0 = cnt_of(pci, 0);
        o0 = pci ? cpu_cnt[0] : pci_cnt[0];
        set_stop(pci, 1'b0);
        wait_g(pci, 6);
        d = cnt_of(pci, 0) - c0;
        chk(d == 3, "R1", {tag, " off latency pulses"}, d, 3);
        c0 = cnt_of(pci, 0);
        wait_g(pci, 8);
        d = cnt_of(pci, 0) - c0;
        chk(d == 0, "R3", {tag, " parked low"}, d, 0);
        od = (pci ? cpu_cnt[0] : pci_cnt[0]) - o0;
        chk(od >= 4, "R6", {tag, " stop leaves other group running"}, od, 4);
        c0 = cnt_of(pci, 0);
        set_stop(pci, 1'b1);
        wait_g(pci, 6);
        d = cnt_of(pci, 0) - c0;
        chk(d == 3, "R2", {tag, " on latency pulses"}, d, 3);
    endtask

    // R4: sweep the offset of a new stop request after a restart.
    task automatic pending_sweep(input bit pci, input int mn);
        int c0, d, exp;
        wait_g(pci, mn + 4);
        set_stop(pci, 1'b0);
        wait_g(pci, 6);
        for (int off = 1; off <= mn + 3; off++) begin
            c0 = cnt_of(pci, 0);
            set_stop(pci, 1'b1);
            wait_g(pci, off);
            set_stop(pci, 1'b0);
            wait_g(pci, mn + off + 8);
            d = cnt_of(pci, 0) - c0;
            exp = (off > mn) ? off : mn;
            chk(d == exp, "R4", pci ? "pci pulses after restart" : "cpu pulses after restart",
                d, exp);
        end
        set_stop(pci, 1'b1);
        wait_g(pci, mn + 6);
    endtask

    // R5: every mask value, each bit checked over four edges.
    task automatic mask_sweep(input bit pci);
        int n, c0 [4], d, exp;
        n = pci ? PN : CN;
        for (int m = 0; m < (1 << n); m++) begin
            if (pci) pci_mask = PN'(m); else cpu_mask = CN'(m);
            for (int i = 0; i < n; i++) c0[i] = cnt_of(pci, i);
            wait_g(pci, 4);
            for (int i = 0; i < n; i++) begin
                d = cnt_of(pci, i) - c0[i];
                exp = m[i] ? 4 : 0;
                chk(d == exp, "R5", pci ? "pci mask bit" : "cpu mask bit", d, exp);
            end
        end
        if (pci) pci_mask = '1; else cpu_mask = '1;
        wait_g(pci, 2);
    endtask

    initial begin
        int c0, f0, d;
        repeat (5) @(negedge cpu_clk);
        rst_n = 1'b1;
        wait_g(1'b0, 1);
        #1;
        chk(drive_en == 1'b1, "R8", "drive enable after reset", drive_en, 1);
        c0 = cpu_cnt[0];
        wait_g(1'b0, 4);
        d = cpu_cnt[0] - c0;
        chk(d == 4, "R9", "cpu running after reset", d, 4);
        // R9: window is closed after reset, so the R1 latency applies at once.
        latency_test(1'b0);
        wait_g(1'b1, 2);
        latency_test(1'b1);

        pending_sweep(1'b0, CMIN);
        pending_sweep(1'b1, PMIN);

        mask_sweep(1'b0);
        mask_sweep(1'b1);

        // R7: free output ignores the stop inputs and follows its enable.
        @(negedge pci_clk);
        pci_stop_n = 1'b0;
        cpu_stop_n = 1'b0;
        wait_g(1'b1, 6);
        f0 = free_cnt;
        c0 = pci_cnt[0];
        wait_g(1'b1, 8);
        d = free_cnt - f0;
        chk(d == 8, "R7", "free output during stops", d, 8);
        d = pci_cnt[0] - c0;
        chk(d == 0, "R3", "pci held low during stop", d, 0);
        free_en = 1'b0;
        f0 = free_cnt;
        wait_g(1'b1, 8);
        d = free_cnt - f0;
        chk(d == 0, "R7", "free output disabled", d, 0);
        free_en = 1'b1;
        pci_stop_n = 1'b1;
        cpu_stop_n = 1'b1;
        wait_g(1'b1, 10);

        // R8: tristate drops the drive enable, clocks keep running.
        @(negedge cpu_clk);
        tristate = 1'b1;
        #1;
        chk(drive_en == 1'b0, "R8", "drive enable with tristate", drive_en, 0);
        c0 = cpu_cnt[0];
        wait_g(1'b0, 4);
        d = cpu_cnt[0] - c0;
        chk(d == 4, "R8", "cpu pulses with tristate", d, 4);
        tristate = 1'b0;
        #1;
        chk(drive_en == 1'b1, "R8", "drive enable restored", drive_en, 1);
        wait_g(1'b0, 4);

        chk(runts == 0, "R3", "shortened high phases", runts, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule